// File: doc/BRIEF.md
# Maskable Interrupt and Alarm Controller

This block gathers three timekeeping events into one interrupt request line. A periodic tick, a time-of-day alarm and the end of each update cycle each raise their own flag. A small enable register decides which of the flags may pull the shared, active-low, open-drain request line. Flags are raised whether or not they are enabled, so software can either take interrupts or poll.

The alarm is evaluated only in the cycle that the update-ended strobe arrives. At that point the live seconds, minutes and hours bytes are compared with three alarm bytes. An alarm byte whose two most significant bits are both 1 matches any value. By choosing which bytes are wildcards, the host gets an alarm once per day, hour, minute or second.

A read strobe stands in for the host's access to the flag register. That access returns the flags and clears them all. A transfer-inhibit level blocks the update-ended source from requesting an interrupt. While the system runs from its backup supply, the host side is locked out, but the alarm path keeps working so that it can wake the system.

Top module: `irq_ctrl`

## Requirements
- R1: A `periodic_evt` pulse sets `flag_q[6]`, an alarm hit sets `flag_q[5]`, and an `update_evt` pulse sets `flag_q[4]`. Each flag is set on the clock edge that samples its event, even when the matching enable bit is 0. `flag_q[3:0]` always read 0.
- R2: `irq_oe` is 1 exactly when some flag is set while its enable bit is effective. The enable bits are `en_q[2]` for periodic, `en_q[1]` for alarm and `en_q[0]` for update-ended. `irq_o` is always 0.
- R3: The summary bit `flag_q[7]` equals the interrupt request, which is the value of `irq_oe`.
- R4: When `flag_rd` is high on a clock edge and `host_lock` is 0, all flags are cleared on that edge. This clears the summary bit and drops `irq_oe`.
- R5: An event sampled on the same edge as a clearing read wins, and its flag stays 1 after that edge.
- R6: On an `update_evt` edge, the alarm flag is set when `cur_hr`, `cur_min` and `cur_sec` all equal `alm_hr`, `alm_min` and `alm_sec`. A mismatch in any one byte leaves the alarm flag at 0.
- R7: An alarm byte with bits [7:6] equal to 2'b11 matches any current value. An alarm byte with bits [7:6] equal to 2'b10 or 2'b01 is compared as a plain value.
- R8: When `xfer_inhibit` is 1, the update-ended flag cannot drive `irq_oe`. The update-ended flag itself is still set.
- R9: When `xfer_inhibit` is 1 on an edge, `en_q[0]` is 0 after that edge. This holds even if the same edge writes a 1 to `en_q[0]`.
- R10: After a synchronous reset, `en_q` is 3'b000, `flag_q` is 8'h00 and `irq_oe` is 0.
- R11: While `host_lock` is 1, `en_wr` and `flag_rd` have no effect. Alarm detection continues and still drives `irq_oe` when the alarm is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periodic_evt | input | 1 | One-cycle periodic tick |
| update_evt | input | 1 | One-cycle end-of-update strobe; also the instant the alarm is compared |
| host_lock | input | 1 | Backup-supply lockout of host writes and reads |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hr | input | 8 | Current hours byte |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hr | input | 8 | Hours alarm byte |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 3 | Enable write data {periodic, alarm, update} |
| xfer_inhibit | input | 1 | Update transfer inhibit level |
| flag_rd | input | 1 | Flag register read strobe (clear on read) |
| en_q | output | 3 | Current enables {periodic, alarm, update} |
| flag_q | output | 8 | Flag register {summary, periodic, alarm, update, 4'b0} |
| irq_oe | output | 1 | Open-drain drive enable; 1 pulls the request line low |
| irq_o | output | 1 | Open-drain data value, constant 0 |

## Verification
The bench builds the block with its defaults: 8-bit bytes, three compared fields and three sources. This covers the full wildcard encoding of the top two bits, and it covers 12-hour values whose bit 7 is set but are not wildcards. A table of time and alarm patterns checks exact matches, single-byte mismatches and each wildcard combination. Directed sequences then cover several cases:
- a read and an event on the same edge;
- transfer inhibit against a write to the update enable;
- lockout during backup while an alarm still fires;
- a reset taken with flags pending.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int BYTE_W     = 8;
    localparam int NUM_FIELDS = 3;
    localparam int NUM_SRC    = 3;
    localparam int RSVD_W     = BYTE_W - NUM_SRC - 1;

    // Source indices; also the enable bit positions
    localparam int SRC_UPD = 0;
    localparam int SRC_ALM = 1;
    localparam int SRC_PER = 2;

    typedef logic [BYTE_W-1:0]  tbyte_t;
    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef struct packed {
        logic              irqf;
        logic              per;
        logic              alm;
        logic              upd;
        logic [RSVD_W-1:0] rsvd;
    } status_t;

    function automatic status_t pack_status(src_vec_t flags, logic req);
        status_t s;
        s.irqf = req;
        s.per  = flags[SRC_PER];
        s.alm  = flags[SRC_ALM];
        s.upd  = flags[SRC_UPD];
        s.rsvd = '0;
        return s;
    endfunction

endpackage

// File: rtl/irq_alarm_cmp.sv
module irq_alarm_cmp #(
    parameter int W = irq_pkg::BYTE_W,
    parameter int N = irq_pkg::NUM_FIELDS
) (
    input  logic [N-1:0][W-1:0] now_i,
    input  logic [N-1:0][W-1:0] alm_i,
    output logic                match_o
);
    localparam int DC_W = 2;

    logic [N-1:0] hit;

    for (genvar g = 0; g < N; g++) begin : g_field
        logic wild;
        assign wild   = &alm_i[g][W-1 -: DC_W];
        assign hit[g] = wild | (now_i[g] == alm_i[g]);
    end

    assign match_o = &hit;

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
    parameter int N       = irq_pkg::NUM_SRC,
    parameter int UPD_IDX = irq_pkg::SRC_UPD
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_i,
    input  logic [N-1:0] wdata_i,
    input  logic         lock_i,
    input  logic         inhibit_i,
    output logic [N-1:0] en_o
);
    logic [N-1:0] en_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_r <= '0;
        end else begin
            if (wr_i && !lock_i)
                en_r <= wdata_i;
            if (inhibit_i)
                en_r[UPD_IDX] <= 1'b0;
        end
    end

    assign en_o = en_r;

    p_inhibit_clears_r9: assert property (@(posedge clk) disable iff (rst)
        inhibit_i |=> !en_o[UPD_IDX]);

    p_lock_holds_r11: assert property (@(posedge clk) disable iff (rst)
        (lock_i && !inhibit_i) |=> $stable(en_o));

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N = irq_pkg::NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flag_r;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flag_r[i] <= 1'b0;
            else if (set_i[i])
                flag_r[i] <= 1'b1;
            else if (clr_i)
                flag_r[i] <= 1'b0;
        end

        p_event_wins_r5: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> flags_o[i]);

        p_read_clears_r4: assert property (@(posedge clk) disable iff (rst)
            (clr_i && !set_i[i]) |=> !flags_o[i]);
    end

    assign flags_o = flag_r;

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int W = irq_pkg::BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         periodic_evt,
    input  logic         update_evt,
    input  logic         host_lock,
    input  logic [W-1:0] cur_sec,
    input  logic [W-1:0] cur_min,
    input  logic [W-1:0] cur_hr,
    input  logic [W-1:0] alm_sec,
    input  logic [W-1:0] alm_min,
    input  logic [W-1:0] alm_hr,
    input  logic         en_wr,
    input  logic [2:0]   en_wdata,
    input  logic         xfer_inhibit,
    input  logic         flag_rd,
    output logic [2:0]   en_q,
    output logic [7:0]   flag_q,
    output logic         irq_oe,
    output logic         irq_o
);
    logic [NUM_FIELDS-1:0][W-1:0] now_bytes;
    logic [NUM_FIELDS-1:0][W-1:0] alm_bytes;
    logic                         alarm_match;
    src_vec_t                     set_vec;
    src_vec_t                     flags;
    src_vec_t                     en_vec;
    src_vec_t                     en_eff;
    logic                         clr;
    logic                         req;
    status_t                      status;

    assign now_bytes = {cur_hr, cur_min, cur_sec};
    assign alm_bytes = {alm_hr, alm_min, alm_sec};

    irq_alarm_cmp #(.W(W), .N(NUM_FIELDS)) u_cmp (
        .now_i   (now_bytes),
        .alm_i   (alm_bytes),
        .match_o (alarm_match)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[SRC_PER] = periodic_evt;
        set_vec[SRC_UPD] = update_evt;
        set_vec[SRC_ALM] = update_evt & alarm_match;
    end

    assign clr = flag_rd & ~host_lock;

    irq_flag_bank #(.N(NUM_SRC)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (set_vec),
        .clr_i   (clr),
        .flags_o (flags)
    );

    irq_enable_reg #(.N(NUM_SRC), .UPD_IDX(SRC_UPD)) u_en (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (en_wr),
        .wdata_i   (en_wdata),
        .lock_i    (host_lock),
        .inhibit_i (xfer_inhibit),
        .en_o      (en_vec)
    );

    always_comb begin
        en_eff          = en_vec;
        en_eff[SRC_UPD] = en_vec[SRC_UPD] & ~xfer_inhibit;
    end

    assign req    = |(flags & en_eff);
    assign status = pack_status(flags, req);

    assign en_q   = en_vec;
    assign flag_q = status;
    assign irq_oe = req;
    assign irq_o  = 1'b0;

    p_reset_release_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_oe && flag_q == 8'h00 && en_q == 3'b000));

    p_read_release_r4: assert property (@(posedge clk) disable iff (rst)
        (flag_rd && !host_lock && !periodic_evt && !update_evt) |=> !irq_oe);

    p_inhibit_mask_r8: assert property (@(posedge clk) disable iff (rst)
        (xfer_inhibit && !en_q[SRC_ALM] && !en_q[SRC_PER]) |-> !irq_oe);

    p_summary_r3: assert property (@(posedge clk) disable iff (rst)
        flag_q[7] == irq_oe);

endmodule

// File: tb/irq_ctrl_bench.sv
`timescale 1ns/1ps
module irq_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       periodic_evt = 1'b0, update_evt = 1'b0, host_lock = 1'b0;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hr = '0;
    logic [7:0] alm_sec = '0, alm_min = '0, alm_hr = '0;
    logic       en_wr = 1'b0;
    logic [2:0] en_wdata = '0;
    logic       xfer_inhibit = 1'b0, flag_rd = 1'b0;
    logic [2:0] en_q;
    logic [7:0] flag_q;
    logic       irq_oe, irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_ctrl u_irq_ctrl (
        .clk(clk), .rst(rst), .periodic_evt(periodic_evt), .update_evt(update_evt),
        .host_lock(host_lock), .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr), .en_wr(en_wr),
        .en_wdata(en_wdata), .xfer_inhibit(xfer_inhibit), .flag_rd(flag_rd),
        .en_q(en_q), .flag_q(flag_q), .irq_oe(irq_oe), .irq_o(irq_o)
    );

    // {cur_hr, cur_min, cur_sec, alm_hr, alm_min, alm_sec, expected alarm}
    localparam int NV = 8;
    localparam logic [48:0] VEC [NV] = '{
        {8'h12, 8'h34, 8'h56, 8'h12, 8'h34, 8'h56, 1'b1},
        {8'h12, 8'h34, 8'h56, 8'h12, 8'h34, 8'h57, 1'b0},
        {8'h07, 8'h34, 8'h56, 8'hC0, 8'h34, 8'h56, 1'b1},
        {8'h03, 8'h21, 8'h56, 8'hFF, 8'hFF, 8'h56, 1'b1},
        {8'h23, 8'h59, 8'h01, 8'hC0, 8'hC0, 8'hC0, 1'b1},
        {8'h12, 8'h00, 8'h00, 8'h80, 8'h00, 8'h00, 1'b0},
        {8'h05, 8'h3F, 8'h10, 8'h05, 8'h7F, 8'h10, 1'b0},
        {8'h92, 8'h15, 8'h30, 8'h92, 8'h15, 8'h30, 1'b1}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_update();
        update_evt = 1'b1; tick(); update_evt = 1'b0;
    endtask

    task automatic pulse_periodic();
        periodic_evt = 1'b1; tick(); periodic_evt = 1'b0;
    endtask

    task automatic do_read();
        flag_rd = 1'b1; tick(); flag_rd = 1'b0;
    endtask

    task automatic write_en(input logic [2:0] v);
        en_wdata = v; en_wr = 1'b1; tick(); en_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R10 reset state
        check("R10 flags", flag_q, 8'h00);
        check("R10 enables", {5'b0, en_q}, 8'h00);
        check("R10 irq_oe", {7'b0, irq_oe}, 8'h00);
        check("R2 irq_o", {7'b0, irq_o}, 8'h00);

        // R6 R7 R1: alarm table with no enables
        for (int i = 0; i < NV; i++) begin
            {cur_hr, cur_min, cur_sec, alm_hr, alm_min, alm_sec} = VEC[i][48:1];
            pulse_update();
            check("R6/R7 alarm flag", {7'b0, flag_q[5]}, {7'b0, VEC[i][0]});
            check("R1 update flag", {7'b0, flag_q[4]}, 8'h01);
            check("R2 no irq while disabled", {7'b0, irq_oe}, 8'h00);
            do_read();
        end

        // R1 periodic flag without enable, then R4 clear
        pulse_periodic();
        check("R1 periodic flag", flag_q, 8'h40);
        do_read();
        check("R4 read clears", flag_q, 8'h00);

        // R2 R3 enabled periodic
        write_en(3'b100);
        check("R2 enable write", {5'b0, en_q}, 8'h04);
        pulse_periodic();
        check("R2 irq asserted", {7'b0, irq_oe}, 8'h01);
        check("R3 summary", flag_q, 8'hC0);
        do_read();
        check("R4 irq released", {7'b0, irq_oe}, 8'h00);
        check("R4 summary cleared", flag_q, 8'h00);

        // R5 event and read on same edge
        periodic_evt = 1'b1; flag_rd = 1'b1; tick();
        periodic_evt = 1'b0; flag_rd = 1'b0;
        check("R5 event wins", flag_q, 8'hC0);
        do_read();

        // R8 update irq enabled without inhibit
        cur_sec = 8'h00; alm_sec = 8'h01; alm_min = 8'h00; alm_hr = 8'h00;
        write_en(3'b001);
        pulse_update();
        check("R8 update irq", {7'b0, irq_oe}, 8'h01);
        do_read();
        // R9 inhibit clears enable
        xfer_inhibit = 1'b1; tick();
        check("R9 inhibit clears uie", {5'b0, en_q}, 8'h00);
        write_en(3'b001);
        check("R9 write blocked by inhibit", {5'b0, en_q}, 8'h00);
        pulse_update();
        check("R8 flag set while inhibited", flag_q, 8'h10);
        check("R8 no irq while inhibited", {7'b0, irq_oe}, 8'h00);
        xfer_inhibit = 1'b0;
        do_read();

        // R11 backup lockout
        write_en(3'b010);
        host_lock = 1'b1;
        write_en(3'b111);
        check("R11 enable write ignored", {5'b0, en_q}, 8'h02);
        cur_hr = 8'h08; cur_min = 8'h30; cur_sec = 8'h00;
        alm_hr = 8'hC0; alm_min = 8'h30; alm_sec = 8'h00;
        pulse_update();
        check("R11 alarm wakes", {7'b0, irq_oe}, 8'h01);
        do_read();
        check("R11 read ignored", flag_q, 8'hB0);
        host_lock = 1'b0;
        do_read();
        check("R4 cleared after unlock", flag_q, 8'h00);

        // R10 reset with pending flags
        write_en(3'b111);
        pulse_periodic();
        rst = 1'b1; tick(); rst = 1'b0;
        check("R10 flags after reset", flag_q, 8'h00);
        check("R10 enables after reset", {5'b0, en_q}, 8'h00);
        check("R10 irq after reset", {7'b0, irq_oe}, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule